// File: doc/BRIEF.md
# Sparsified Pixel Readout Engine

This block drains one readout group of 256 pixels. Each pixel shows a 5-bit count, and only pixels whose count is non-zero get read. A priority encoder picks a pixel. The engine then sends that pixel's address and count as one serial word. One cycle after the last bit it pulses a strobe to that pixel, and the pixel swaps in its other counter. A group-wide flag shows whether any pixel still holds a hit. Sixteen copies run side by side, one for each group, with nothing shared between them.

Readout is paced by the strobe. After each strobe the engine looks at the same pixel again. It stays on that pixel while the swapped-in count is non-zero, even if a higher-numbered pixel has gained a hit in the meantime. Only when that count is zero does the encoder pick again, and it then takes the highest-numbered pixel that has a hit. When no hit remains, the engine rests in idle with its outputs quiet.

Top module: `hitscan_readout`

## Requirements
- R1: When the engine picks a pixel from idle, or after the kept pixel's count reads zero, it takes the highest-numbered pixel with a non-zero count. Pixel i's count sits at bits [5i+4:5i] of `pix_cnt`.
- R2: Each word is 13 bits, sent on `ser_dout` MSB first: the 8-bit pixel address, then the 5-bit count. `frame_vld` is high for exactly those 13 consecutive cycles.
- R3: In the cycle right after the last bit of a word, `pix_strobe` is one-hot on the pixel just sent, for one cycle only. `pix_strobe` is zero in every other cycle.
- R4: If the strobed pixel's count is non-zero in the cycle after the strobe, the next word carries that same pixel, whatever other pixels hold.
- R5: Evaluation takes one cycle after the strobe. The next word's `frame_vld` therefore starts two cycles after the strobe cycle whenever any count is non-zero at that point.
- R6: `any_hit` is high in the same cycle exactly when at least one pixel count is non-zero.
- R7: While no pixel count is non-zero, `ser_dout`, `frame_vld` and `pix_strobe` stay low.
- R8: `rst` is synchronous and active-high. It stops any word in progress and drives `ser_dout`, `frame_vld` and `pix_strobe` low. After release, the next pick follows R1.
- R9: From idle, `frame_vld` rises in the cycle after the first cycle in which `any_hit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_cnt | input | 1280 | Current count of each pixel, 5 bits per pixel, pixel 0 in the lowest bits |
| ser_dout | output | 1 | Serial word bit, MSB first |
| frame_vld | output | 1 | High while a word's bits are on `ser_dout` |
| pix_strobe | output | 256 | One-hot strobe that tells the selected pixel to swap counters |
| any_hit | output | 1 | OR over the group of non-zero pixel counts |

## Verification
`any_hit` is combinational and is compared in every cycle. The bench samples each result on the falling edge of the cycle it belongs to. Counting from the cycle in which counts first appear, `frame_vld` is low at the first falling edge and high at the second. Bits then arrive on 13 falling edges in a row. The strobe shows up on the 14th falling edge. At the second falling edge after that, a new word must have started if the bench's pixel model still holds a hit.

The pixel model swaps counters on the strobe falling edge. Its counts change only then and during stimulus writes made just after a rising edge. For that reason the expected address and count are computed from the model at the first bit of each word.

// File: rtl/hitscan_pkg.sv
package hitscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_STROBE = 2'd2,
    ST_CHECK  = 2'd3
  } rd_state_t;

endpackage

// File: rtl/hitscan_prio_enc.sv
module hitscan_prio_enc #(
  parameter int N  = 256,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  nz,
  output logic [AW-1:0] top_idx,
  output logic          top_valid
);

  // later indices overwrite earlier ones, so the highest set bit wins
  always_comb begin
    top_idx   = '0;
    top_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (nz[i]) begin
        top_idx   = AW'(i);
        top_valid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hitscan_serializer.sv
module hitscan_serializer #(
  parameter int WW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [WW-1:0] word,
  output logic          sdo,
  output logic          busy,
  output logic          last
);

  localparam int RW = $clog2(WW + 1);

  logic [WW-1:0] sreg;
  logic [RW-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      rem  <= '0;
    end else if (load) begin
      sreg <= word;
      rem  <= RW'(WW);
    end else if (rem != '0) begin
      sreg <= {sreg[WW-2:0], 1'b0};
      rem  <= rem - RW'(1);
    end
  end

  assign busy = (rem != '0);
  assign last = (rem == RW'(1));
  assign sdo  = busy & sreg[WW-1];

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(last));

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy && !last));

endmodule

// File: rtl/hitscan_readout.sv
module hitscan_readout #(
  parameter int NPIX = 256,
  parameter int CW   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPIX*CW-1:0]   pix_cnt,
  output logic                 ser_dout,
  output logic                 frame_vld,
  output logic [NPIX-1:0]      pix_strobe,
  output logic                 any_hit
);
  import hitscan_pkg::*;

  localparam int AW = $clog2(NPIX);
  localparam int WW = AW + CW;

  function automatic logic [CW-1:0] cnt_at(input logic [NPIX*CW-1:0] v,
                                           input logic [AW-1:0] idx);
    return v[int'(idx)*CW +: CW];
  endfunction

  function automatic logic [WW-1:0] pack_word(input logic [AW-1:0] addr,
                                              input logic [CW-1:0] cnt);
    return {addr, cnt};
  endfunction

  rd_state_t     state, state_nx;
  logic [AW-1:0] sel;
  logic [NPIX-1:0] nz;
  logic [AW-1:0] enc_idx;
  logic          enc_valid;
  logic [CW-1:0] sel_cnt, enc_cnt, load_cnt;
  logic [AW-1:0] load_addr;
  logic          keep_sel, take_enc, load;
  logic          ser_last, ser_busy, strobe_now;

  genvar g;
  generate
    for (g = 0; g < NPIX; g++) begin : g_pix
      assign nz[g]         = |pix_cnt[g*CW +: CW];
      assign pix_strobe[g] = strobe_now && (sel == AW'(g));
    end
  endgenerate

  assign any_hit = |nz;

  hitscan_prio_enc #(.N(NPIX), .AW(AW)) u_enc (
    .nz       (nz),
    .top_idx  (enc_idx),
    .top_valid(enc_valid)
  );

  assign sel_cnt    = cnt_at(pix_cnt, sel);
  assign enc_cnt    = cnt_at(pix_cnt, enc_idx);
  assign keep_sel   = (state == ST_CHECK) && (sel_cnt != '0);
  assign take_enc   = ((state == ST_IDLE) || (state == ST_CHECK)) && !keep_sel && enc_valid;
  assign load       = keep_sel || take_enc;
  assign load_addr  = keep_sel ? sel : enc_idx;
  assign load_cnt   = keep_sel ? sel_cnt : enc_cnt;
  assign strobe_now = (state == ST_STROBE);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (load) state_nx = ST_SHIFT;
      ST_SHIFT:  if (ser_last) state_nx = ST_STROBE;
      ST_STROBE: state_nx = ST_CHECK;
      ST_CHECK:  state_nx = load ? ST_SHIFT : ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      sel   <= '0;
    end else begin
      state <= state_nx;
      if (load) sel <= load_addr;
    end
  end

  hitscan_serializer #(.WW(WW)) u_ser (
    .clk (clk),
    .rst (rst),
    .load(load),
    .word(pack_word(load_addr, load_cnt)),
    .sdo (ser_dout),
    .busy(ser_busy),
    .last(ser_last)
  );

  assign frame_vld = ser_busy;

  // R6
  any_or_chk: assert property (@(posedge clk) disable iff (rst)
    any_hit == enc_valid);

  // R1
  enc_pick_chk: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> (enc_cnt != '0));

  // R3
  strobe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pix_strobe));

  // R3
  strobe_after_chk: assert property (@(posedge clk) disable iff (rst)
    ser_last |=> ((pix_strobe != '0) && !frame_vld));

  // R4
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    keep_sel |=> (frame_vld && (sel == $past(sel))));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !any_hit) |=> !frame_vld);

endmodule

// File: tb/sim_hitscan_readout.sv
`timescale 1ns/1ps
module sim_hitscan_readout;
  localparam int NPIX = 256;
  localparam int CW   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPIX*CW-1:0] pix_cnt;
  logic ser_dout, frame_vld, any_hit;
  logic [NPIX-1:0] pix_strobe;

  int n_chk = 0;
  int n_bad = 0;

  // pixel model: two counters, one active
  int cA [NPIX];
  int cB [NPIX];
  bit act [NPIX];

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NPIX; i++)
      pix_cnt[i*CW +: CW] = act[i] ? cB[i][CW-1:0] : cA[i][CW-1:0];
  end

  hitscan_readout #(.NPIX(NPIX), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .pix_cnt(pix_cnt), .ser_dout(ser_dout),
    .frame_vld(frame_vld), .pix_strobe(pix_strobe), .any_hit(any_hit)
  );

  task automatic chk(input bit ok, input string req, input longint actv, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actv, expv, $time);
    end
  endtask

  function automatic int cur(input int i);
    return act[i] ? cB[i] : cA[i];
  endfunction

  function automatic bit model_hit();
    for (int i = 0; i < NPIX; i++) if (cur(i) != 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int highest();
    for (int i = NPIX - 1; i >= 0; i--) if (cur(i) != 0) return i;
    return -1;
  endfunction

  // word checker and pixel swap, on falling edges
  int bits = 0;
  logic [12:0] acc;
  int exp_addr, exp_cnt, prev = -1, since = -1, words = 0;
  bit kept;

  always @(negedge clk) begin
    if (rst) begin
      bits = 0; prev = -1; since = -1;
    end else begin
      bit h;
      h = model_hit();
      // R6
      chk(any_hit == h, "R6", any_hit, h);
      // R7
      if (!h) chk(!frame_vld && !ser_dout && pix_strobe == '0, "R7", frame_vld, 0);
      if (since >= 0) since++;
      // R5
      if (since == 2) begin
        chk(frame_vld == h, "R5", frame_vld, h);
        since = -1;
      end
      if (!h && bits == 0) prev = -1;
      if (frame_vld) begin
        if (bits == 0) begin
          kept = (prev >= 0) && (cur(prev) != 0);
          exp_addr = kept ? prev : highest();
          exp_cnt = cur(exp_addr);
        end
        acc = {acc[11:0], ser_dout};
        bits++;
        if (bits == 13) begin
          // R2 word layout, R1 or R4 pixel choice
          chk(acc == {exp_addr[7:0], exp_cnt[4:0]}, kept ? "R4" : "R1",
              acc, {exp_addr[7:0], exp_cnt[4:0]});
        end else if (bits > 13) begin
          chk(1'b0, "R2", bits, 13);
        end
      end else begin
        if (bits == 13) begin
          logic [NPIX-1:0] oh;
          oh = '0; oh[exp_addr] = 1'b1;
          // R3
          chk(pix_strobe == oh && !ser_dout, "R3", $countones(pix_strobe), 1);
          if (act[exp_addr]) cB[exp_addr] = 0; else cA[exp_addr] = 0;
          act[exp_addr] = ~act[exp_addr];
          prev = exp_addr;
          since = 0;
          words++;
        end else begin
          if (bits != 0) chk(1'b0, "R2", bits, 13);
          // R3 no strobe outside its slot
          chk(pix_strobe == '0, "R3", $countones(pix_strobe), 0);
        end
        bits = 0;
      end
    end
  end

  task automatic clear_model();
    for (int i = 0; i < NPIX; i++) begin cA[i] = 0; cB[i] = 0; act[i] = 1'b0; end
  endtask

  task automatic drain(input int exp_words, input int w0, input string req);
    int n = 0;
    while (model_hit() && n < 20000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    chk(words - w0 == exp_words, req, words - w0, exp_words);
  endtask

  initial begin
    int w0;
    clear_model();
    // watchdog
    fork
      begin
        #(5ns * 190000);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk(!frame_vld && !ser_dout && pix_strobe == '0 && !any_hit, "R8", frame_vld, 0);
    @(posedge clk); #1 rst = 1'b0;

    // S1: pixel 0 alone, latency from idle
    w0 = words;
    @(posedge clk); #1 cA[0] = 1;
    @(negedge clk);
    // R9
    chk(frame_vld == 1'b0, "R9", frame_vld, 0);
    @(negedge clk);
    chk(frame_vld == 1'b1, "R9", frame_vld, 1);
    drain(1, w0, "R1");

    // S2: top pixel, both counters full
    w0 = words;
    @(posedge clk); #1 clear_model(); cA[255] = 31; cB[255] = 31;
    drain(2, w0, "R4");

    // S3: several pixels
    w0 = words;
    @(posedge clk); #1 clear_model();
    cA[3] = 5; cA[77] = 2; cB[77] = 9; cA[128] = 17; cB[200] = 6;
    drain(4, w0, "R1");

    // S4: higher pixel appears while lower one is kept
    w0 = words;
    @(posedge clk); #1 clear_model(); cA[10] = 3; cB[10] = 4;
    repeat (5) @(posedge clk);
    #1 cA[250] = 7;
    drain(3, w0, "R4");

    // S5: full sweep of all pixels and count values
    w0 = words;
    @(posedge clk); #1 clear_model();
    begin
      int expw = 0;
      for (int i = 0; i < NPIX; i++) begin
        cA[i] = i % 32;
        cB[i] = (cA[i] != 0) ? (i * 5 + 3) % 32 : 0;
        expw += (cA[i] != 0) + (cB[i] != 0);
      end
      drain(expw, w0, "R5");
    end

    // S6: reset in the middle of a word
    @(posedge clk); #1 clear_model(); cA[100] = 9; cB[100] = 2; cA[50] = 1;
    repeat (7) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); @(negedge clk);
    // R8
    chk(!frame_vld && !ser_dout && pix_strobe == '0, "R8", frame_vld, 0);
    @(posedge clk); #1 rst = 1'b0;
    w0 = words;
    drain(3, w0, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule